// File: doc/BRIEF.md
# DMA Cycle Clock Speed Switcher

This block generates the clocks for a SCSI controller and for a DMA controller on an expansion card. Its timing sources are the host bus's two 3.5 MHz quadrature clocks and a 7 MHz reference. It does not produce real clocks. Instead it emits single-cycle clock-enable pulses that are synchronous to one fast system clock (nominally 28 MHz). A normal-rate pulse marks each rising edge of the 7 MHz reference. A double-rate pulse marks every edge of either quadrature clock.

A speed jumper selects between two modes:

- **Normal mode (jumper open):** both consumers get normal-rate pulses.
- **Accelerated mode (jumper closed):** the SCSI controller gets a continuous double-rate pulse train. The DMA controller speeds up only in the late states of one kind of bus cycle. That cycle is a DMA write to fast RAM that the card itself owns.

During such a qualified cycle the block also takes over bus termination. It drives the override request for the whole cycle and raises its own data acknowledge from state S4 onward. The DMA controller's rate changes only on a normal-rate pulse, where both pulse trains coincide, so no shortened clock period is ever produced. A RAM target that serves an accelerated cycle has to complete within three 7 MHz periods. That limit is a constraint on the target, not logic inside this block.

Top module: `dma_speed_switch`

## Requirements
- R1: A normal tick is one system-clock-wide pulse following each rising edge of the 7 MHz reference. A double-rate tick follows every edge, rising or falling, of either quadrature clock. All inputs pass through a two-stage synchronizer.
- R2: When `speed_jumper` is 0 (open), `scsi_clk_en` and `dmac_clk_en` both pulse once per 7 MHz period, which is 16 pulses in 64 system clocks when the input phases are aligned.
- R3: When `speed_jumper` is 1 (closed), `scsi_clk_en` pulses on every double-rate tick, which is 32 pulses in 64 system clocks.
- R4: With the jumper closed, `dmac_clk_en` runs at double rate only while a qualified cycle is in state S4 or later. Outside such cycles it stays at the normal rate.
- R5: A cycle qualifies when all of the following hold when address strobe (`as_n`) falls:
  - `speed_jumper` is 1;
  - `own_n` is 0;
  - `rw` is 0 (write), so tying `rw` low qualifies every owned DMA cycle;
  - `addr_hi` (address bits 23..21) lies within FAST_MIN..FAST_MAX, which is 1..4 by default.
  Reads, unowned cycles and addresses outside that range never qualify.
- R6: `ovr_o` is high throughout a qualified cycle from its start. `dtack_o` rises only after `ovr_o` is already high, at state S4, which is two double-rate ticks after the strobe falls (state S2). `dtack_o` is never high without `ovr_o`.
- R7: `ovr_o` and `dtack_o` are both low within 4 system clocks (one 7 MHz period) after `as_n` is negated. They are never high outside a qualified cycle.
- R8: The DMA controller's rate switches only on a normal tick. Successive `dmac_clk_en` pulses are therefore 2 or 4 system clocks apart, and every `dmac_clk_en` pulse coincides with a `scsi_clk_en` pulse.
- R9: After reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4x the 7 MHz rate) |
| rst | input | 1 | Synchronous active-high reset |
| quad_a | input | 1 | First 3.5 MHz quadrature bus clock |
| quad_b | input | 1 | Second 3.5 MHz quadrature bus clock, 90 degrees shifted |
| ref7 | input | 1 | 7 MHz reference clock |
| speed_jumper | input | 1 | 1 = accelerated mode, 0 = normal mode |
| as_n | input | 1 | Bus address strobe, active low |
| own_n | input | 1 | Card bus-ownership signal, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | ADDR_W | Address bits 23..21 |
| scsi_clk_en | output | 1 | Clock-enable pulse for the SCSI controller |
| dmac_clk_en | output | 1 | Clock-enable pulse for the DMA controller |
| ovr_o | output | 1 | Override request (active high, to an open-collector driver) |
| dtack_o | output | 1 | Data acknowledge (active high, to an open-collector driver) |

## Verification
Three outputs can act in the same system cycle: the DMA clock's rate change, the start of termination (`dtack_o` rising at S4), and the release of termination at strobe negation. The bench provokes this overlap with random short bus cycles whose strobe edges fall at random quadrature phases, mixed with directed cycles at the address-range boundaries. A continuous monitor judges every `dmac_clk_en` interval against the 2-or-4 rule. It also checks that each DMA pulse coincides with a SCSI pulse and that termination is never held outside a strobe. In parallel, per-cycle checks compare whether a double-rate interval, override and acknowledge appeared against the qualification the bench computes from the inputs it drove.

// File: rtl/dma_clk_pkg.sv
package dma_clk_pkg;
  typedef logic [2:0] bus_state_t;
  localparam bus_state_t ST_STROBE = 3'd2;  // state in which the strobe is first seen
  localparam bus_state_t ST_FAST   = 3'd4;  // first accelerated / terminated state
  localparam bus_state_t ST_LAST   = 3'd7;  // counter saturates here
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tick_gen.sv
module tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic qa,
  input  logic qb,
  input  logic r7,
  output logic fast_tick,
  output logic slow_tick
);
  logic qa_d, qb_d, r7_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      qa_d <= 1'b0;
      qb_d <= 1'b0;
      r7_d <= 1'b0;
    end else begin
      qa_d <= qa;
      qb_d <= qb;
      r7_d <= r7;
    end
  end

  assign fast_tick = (qa ^ qa_d) | (qb ^ qb_d);
  assign slow_tick = r7 & ~r7_d;

  // a normal tick never directly follows another one
  AST_SLOW_SPACED: assert property (@(posedge clk) disable iff (rst)
    slow_tick |=> !slow_tick); // R1
endmodule

// File: rtl/cycle_track.sv
module cycle_track
  import dma_clk_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int FAST_MIN = 1,
  parameter int FAST_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_tick,
  input  logic              accel,
  input  logic              as_n,
  input  logic              own_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr_hi,
  output logic              ovr_q,
  output logic              dtack_q,
  output logic              fast_win
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(FAST_MIN);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(FAST_MAX);

  logic       as_act, as_prev, start, hit, qual_now, qual;
  bus_state_t st;

  assign as_act   = ~as_n;
  assign start    = as_act & ~as_prev;
  assign hit      = (addr_hi >= LO) && (addr_hi <= HI);
  assign qual_now = accel & ~own_n & ~rw & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_prev  <= 1'b0;
      st       <= ST_STROBE;
      qual     <= 1'b0;
      ovr_q    <= 1'b0;
      dtack_q  <= 1'b0;
      fast_win <= 1'b0;
    end else begin
      as_prev <= as_act;
      if (start) begin
        st   <= ST_STROBE;
        qual <= qual_now;
      end else if (!as_act) begin
        qual <= 1'b0;
      end else if (fast_tick && st != ST_LAST) begin
        st <= st + 3'd1;
      end
      ovr_q    <= as_act & (start ? qual_now : qual);
      dtack_q  <= as_act & ~start & qual & (st >= ST_FAST);
      fast_win <= as_act & ~start & qual & (st >= ST_FAST);
    end
  end

  AST_DTACK_NEEDS_OVR: assert property (@(posedge clk) disable iff (rst)
    dtack_q |-> ovr_q); // R6
  AST_OVR_LEADS_DTACK: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_q) |-> $past(ovr_q)); // R6
  AST_RELEASE_ON_NEGATE: assert property (@(posedge clk) disable iff (rst)
    !as_act |=> (!ovr_q && !dtack_q)); // R7
  AST_NO_ACCEL_READ: assert property (@(posedge clk) disable iff (rst)
    (start && rw) |=> !ovr_q); // R5
endmodule

// File: rtl/rate_sel.sv
module rate_sel (
  input  logic clk,
  input  logic rst,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic accel,
  input  logic fast_win,
  output logic scsi_en,
  output logic dmac_en
);
  logic fast_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_mode <= 1'b0;
      scsi_en   <= 1'b0;
      dmac_en   <= 1'b0;
    end else begin
      if (slow_tick) fast_mode <= accel & fast_win;
      scsi_en <= accel ? fast_tick : slow_tick;
      dmac_en <= slow_tick | (fast_mode & fast_tick);
    end
  end

  AST_SWITCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (fast_mode != $past(fast_mode)) |-> $past(slow_tick)); // R8
  AST_DMAC_IN_SCSI: assert property (@(posedge clk) disable iff (rst)
    (dmac_en && accel && $past(accel)) |-> scsi_en); // R8
  AST_OPEN_NO_FAST: assert property (@(posedge clk) disable iff (rst)
    (!accel && $past(!accel) && $past(!fast_mode)) |-> !fast_mode); // R2
endmodule

// File: rtl/dma_speed_switch.sv
module dma_speed_switch #(
  parameter int ADDR_W      = 3,
  parameter int FAST_MIN    = 1,
  parameter int FAST_MAX    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              quad_a,
  input  logic              quad_b,
  input  logic              ref7,
  input  logic              speed_jumper,
  input  logic              as_n,
  input  logic              own_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr_hi,
  output logic              scsi_clk_en,
  output logic              dmac_clk_en,
  output logic              ovr_o,
  output logic              dtack_o
);
  localparam int IN_W = 7 + ADDR_W;
  // order: quad_a, quad_b, ref7, jumper, as_n, own_n, rw, addr
  localparam logic [IN_W-1:0] IN_RST = {4'b0000, 3'b111, {ADDR_W{1'b0}}};

  logic [IN_W-1:0]   raw, syn;
  logic              s_qa, s_qb, s_r7, s_jmp, s_as_n, s_own_n, s_rw;
  logic [ADDR_W-1:0] s_addr;
  logic              fast_tick, slow_tick, fast_win;

  assign raw = {quad_a, quad_b, ref7, speed_jumper, as_n, own_n, rw, addr_hi};

  in_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign {s_qa, s_qb, s_r7, s_jmp, s_as_n, s_own_n, s_rw, s_addr} = syn;

  tick_gen u_ticks (
    .clk(clk), .rst(rst), .qa(s_qa), .qb(s_qb), .r7(s_r7),
    .fast_tick(fast_tick), .slow_tick(slow_tick)
  );

  cycle_track #(.ADDR_W(ADDR_W), .FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX)) u_cyc (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .accel(s_jmp),
    .as_n(s_as_n), .own_n(s_own_n), .rw(s_rw), .addr_hi(s_addr),
    .ovr_q(ovr_o), .dtack_q(dtack_o), .fast_win(fast_win)
  );

  rate_sel u_rate (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .accel(s_jmp), .fast_win(fast_win),
    .scsi_en(scsi_clk_en), .dmac_en(dmac_clk_en)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!ovr_o && !dtack_o && !scsi_clk_en && !dmac_clk_en)); // R9
endmodule

// File: tb/tb_dma_speed_switch.sv
module tb_dma_speed_switch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       quad_a = 1'b0, quad_b = 1'b0, ref7 = 1'b0;
  logic       speed_jumper = 1'b0;
  logic       as_n = 1'b1, own_n = 1'b1, rw = 1'b1;
  logic [2:0] addr_hi = 3'd0;
  logic       scsi_clk_en, dmac_clk_en, ovr_o, dtack_o;

  int checks = 0, fails = 0, cyc = 0;
  int last_dmac = -1, spacing_bad = 0, idle_bad = 0, as_hi_cnt = 0;
  int scsi_cnt = 0, dmac_cnt = 0;
  bit fast_seen = 0, ovr_seen = 0, dtack_seen = 0, done = 0;

  dma_speed_switch dut (
    .clk(clk), .rst(rst), .quad_a(quad_a), .quad_b(quad_b), .ref7(ref7),
    .speed_jumper(speed_jumper), .as_n(as_n), .own_n(own_n), .rw(rw),
    .addr_hi(addr_hi), .scsi_clk_en(scsi_clk_en), .dmac_clk_en(dmac_clk_en),
    .ovr_o(ovr_o), .dtack_o(dtack_o)
  );

  always #2 clk = ~clk;

  // quadrature phase generator: 8 system clocks per 3.5 MHz period
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      quad_a = (ph < 4);
      quad_b = (ph >= 2) && (ph < 6);
      ref7   = ph[1];
      ph = (ph + 1) % 8;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_accel(input bit j, input bit own, input bit r, input int a);
    return j && !own && !r && (a >= 1) && (a <= 4);
  endfunction

  // monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (scsi_clk_en) scsi_cnt++;
        if (dmac_clk_en) begin
          dmac_cnt++;
          if (!scsi_clk_en) spacing_bad++;
          if (last_dmac >= 0) begin
            if (cyc - last_dmac == 2) fast_seen = 1;
            else if (cyc - last_dmac != 4) spacing_bad++;
          end
          last_dmac = cyc;
        end
        if (ovr_o) ovr_seen = 1;
        if (dtack_o) dtack_seen = 1;
        if (dtack_o && !ovr_o) idle_bad++;
        as_hi_cnt = as_n ? as_hi_cnt + 1 : 0;
        if (as_hi_cnt > 4 && (ovr_o || dtack_o)) idle_bad++;
      end
      if (cyc > 150000 && !done) begin
        check(0, "watchdog", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_window(output int s, output int d);
    scsi_cnt = 0;
    dmac_cnt = 0;
    wait_clk(64);
    s = scsi_cnt;
    d = dmac_cnt;
  endtask

  task automatic run_cycle(input bit j, input bit own, input bit r, input int a, input int len);
    bit e;
    e = exp_accel(j, own, r, a);
    speed_jumper = j;
    own_n = own;
    rw = r;
    addr_hi = 3'(a);
    wait_clk(14);
    fast_seen = 0;
    ovr_seen = 0;
    dtack_seen = 0;
    as_n = 1'b0;
    wait_clk(len);
    as_n = 1'b1;
    wait_clk(4);
    check(!ovr_o && !dtack_o, "R7 release", {ovr_o, dtack_o}, 0);
    wait_clk(10);
    check(ovr_seen == e, "R5/R6 ovr", ovr_seen, e);
    check(dtack_seen == e, "R6 dtack", dtack_seen, e);
    check(fast_seen == e, "R4 dmac double rate", fast_seen, e);
    own_n = 1'b1;
    rw = 1'b1;
  endtask

  initial begin
    int s, d;
    int seed;
    seed = $urandom(32'h2091);
    wait_clk(6);
    check(!scsi_clk_en && !dmac_clk_en && !ovr_o && !dtack_o, "R9 reset",
          {scsi_clk_en, dmac_clk_en, ovr_o, dtack_o}, 0);
    rst = 1'b0;
    wait_clk(10);

    // R1/R2 normal rate with the jumper open
    count_window(s, d);
    check(s == 16, "R2 scsi normal", s, 16);
    check(d == 16, "R2 dmac normal", d, 16);
    speed_jumper = 1'b1;
    wait_clk(12);
    count_window(s, d);
    check(s == 32, "R3 scsi double", s, 32);
    check(d == 16, "R4 dmac idle normal", d, 16);

    // directed corner cases
    run_cycle(1, 0, 0, 2, 16);   // R5 qualified write
    run_cycle(1, 0, 1, 2, 16);   // R5 read does not qualify
    run_cycle(1, 1, 0, 2, 16);   // R5 not owned
    run_cycle(1, 0, 0, 0, 16);   // R5 below range
    run_cycle(1, 0, 0, 1, 16);   // R5 lower bound
    run_cycle(1, 0, 0, 4, 16);   // R5 upper bound
    run_cycle(1, 0, 0, 5, 16);   // R5 above range
    run_cycle(1, 0, 0, 7, 16);   // R5 top space
    run_cycle(0, 0, 0, 3, 16);   // R2 jumper open

    // random cycles
    for (int i = 0; i < 40; i++) begin
      run_cycle(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
                int'($urandom % 8), 12 + int'($urandom % 8));
      wait_clk(int'($urandom % 5));
    end

    check(spacing_bad == 0, "R8 dmac spacing", spacing_bad, 0);
    check(idle_bad == 0, "R7 termination outside cycle", idle_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule